// File: doc/BRIEF.md
# Redirected Predicate Mask Lookup

This block produces the per-element predicate mask for a vector operation. Software loads a small key-value table. Each key is a register number together with its class, integer or floating-point. Each value names the integer register that holds the predicate bits. The value also carries a flag that complements the whole mask and a flag that selects zeroing of masked-off elements.

When a lookup request arrives, the block searches the table for the operation's register. On a hit it issues a synchronous read of the redirected integer register. When the data returns, it applies the optional inversion and presents an XLEN-bit mask with the zeroing flag. A register that has no table entry gets an all-ones mask with zeroing off, and no register read is issued. Requests are fully pipelined, so one can be accepted on every clock.

Top module: `pred_redirect`

## Requirements
- R1: While rst_ni is low, every table entry is invalid and both mask_valid_o and rf_rd_en_o are low.
- R2: A table write (cfg_we_i high at a rising edge) updates slot cfg_idx_i. A request sampled on the next rising edge already sees the new contents.
- R3: A request matches an entry only when the entry is valid and both the class bit and the register number are equal. The class bit is 0 for integer and 1 for floating-point.
- R4: On a hit, rf_rd_en_o is high for exactly the one cycle after the request edge, and rf_rd_addr_o carries the entry's redirect index.
- R5: The request is sampled at edge k, and the read data is sampled at edge k+2. mask_valid_o is high during the cycle after edge k+2.
- R6: On a hit with the invert flag set, mask_o equals the bitwise complement of the returned register value.
- R7: On a hit with the invert flag clear, mask_o equals the returned register value.
- R8: On a miss, mask_o is all ones, zero_mode_o is 0 and rf_rd_en_o stays low.
- R9: On a hit, zero_mode_o equals the entry's zeroing flag.
- R10: When several valid entries match, the entry in the highest-numbered slot decides the result.
- R11: Integer and floating-point registers with the same number are distinct keys.
- R12: Requests on consecutive cycles each produce their own result on consecutive cycles, in order.
- R13: Writing a slot with cfg_valid_i low removes that slot from lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Table write strobe |
| cfg_idx_i | input | $clog2(NUM_ENTRIES) | Slot to write |
| cfg_valid_i | input | 1 | Entry valid bit to store |
| cfg_is_fp_i | input | 1 | Key class: 0 integer, 1 floating-point |
| cfg_key_i | input | 5 | Key register number |
| cfg_pred_idx_i | input | 5 | Integer register that holds the predicate |
| cfg_invert_i | input | 1 | Complement the mask |
| cfg_zero_i | input | 1 | Zero masked-off elements |
| req_valid_i | input | 1 | Lookup request |
| req_is_fp_i | input | 1 | Request class: 0 integer, 1 floating-point |
| req_reg_i | input | 5 | Request register number |
| rf_rd_en_o | output | 1 | Register read enable |
| rf_rd_addr_o | output | 5 | Register read address |
| rf_rd_data_i | input | XLEN | Read data, valid the cycle after the address is sampled |
| mask_valid_o | output | 1 | Result valid |
| mask_o | output | XLEN | Predicate mask |
| zero_mode_o | output | 1 | Zeroing mode for masked-off elements |

## Verification
The assertions check, on every cycle, that reads only follow requests and that results appear at a fixed latency. They also check that the reset state is quiet and that a result with no read behind it is all ones with zeroing off. Only the bench's scenarios can show the key decoding. This covers class separation, slot priority, entry removal, write-then-lookup timing and the correct redirect address and inversion of the data. Each of these depends on the table contents that the bench programmed.

// File: rtl/pred_redir_pkg.sv
package pred_redir_pkg;
  localparam int unsigned REG_IDX_W = 5;

  typedef struct packed {
    logic                 valid;
    logic                 is_fp;
    logic [REG_IDX_W-1:0] key;
    logic [REG_IDX_W-1:0] pred_idx;
    logic                 invert;
    logic                 zeroing;
  } pred_entry_t;
endpackage

// File: rtl/pred_table.sv
module pred_table
  import pred_redir_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 16,
  localparam int unsigned IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  pred_entry_t wdata_i,
  output pred_entry_t entries_o [NUM_ENTRIES]
);
  pred_entry_t mem_q [NUM_ENTRIES];

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[g] <= '0;
      end else if (we_i && (idx_i == IDX_W'(g))) begin
        mem_q[g] <= wdata_i;
      end
    end
    assign entries_o[g] = mem_q[g];
  end
endmodule

// File: rtl/pred_match.sv
module pred_match
  import pred_redir_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 16
) (
  input  pred_entry_t          entries_i [NUM_ENTRIES],
  input  logic                 is_fp_i,
  input  logic [REG_IDX_W-1:0] reg_i,
  output logic                 hit_o,
  output pred_entry_t          sel_o
);
  logic [NUM_ENTRIES-1:0] match;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
    assign match[g] = entries_i[g].valid && (entries_i[g].is_fp == is_fp_i) &&
                      (entries_i[g].key == reg_i);
  end

  // ascending scan: last (highest) match wins
  always_comb begin
    hit_o = 1'b0;
    sel_o = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (match[i]) begin
        hit_o = 1'b1;
        sel_o = entries_i[i];
      end
    end
  end
endmodule

// File: rtl/pred_mask_stage.sv
module pred_mask_stage
  import pred_redir_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic                 hit_i,
  input  pred_entry_t          sel_i,
  output logic                 rd_en_o,
  output logic [REG_IDX_W-1:0] rd_addr_o,
  input  logic [XLEN-1:0]      rd_data_i,
  output logic                 mask_valid_o,
  output logic [XLEN-1:0]      mask_o,
  output logic                 zero_mode_o
);
  logic                 s1_valid, s1_hit, s1_inv, s1_zero;
  logic [REG_IDX_W-1:0] s1_addr;
  logic                 s2_valid, s2_hit, s2_inv, s2_zero;
  logic                 s3_valid, s3_zero;
  logic [XLEN-1:0]      s3_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0; s1_hit <= 1'b0; s1_inv <= 1'b0; s1_zero <= 1'b0;
      s1_addr  <= '0;
      s2_valid <= 1'b0; s2_hit <= 1'b0; s2_inv <= 1'b0; s2_zero <= 1'b0;
      s3_valid <= 1'b0; s3_zero <= 1'b0; s3_mask <= '0;
    end else begin
      s1_valid <= req_valid_i;
      s1_hit   <= req_valid_i & hit_i;
      s1_inv   <= sel_i.invert;
      s1_zero  <= sel_i.zeroing;
      s1_addr  <= sel_i.pred_idx;
      s2_valid <= s1_valid;
      s2_hit   <= s1_hit;
      s2_inv   <= s1_inv;
      s2_zero  <= s1_zero;
      s3_valid <= s2_valid;
      s3_zero  <= s2_hit & s2_zero;
      s3_mask  <= s2_hit ? (rd_data_i ^ {XLEN{s2_inv}}) : '1;
    end
  end

  assign rd_en_o      = s1_valid & s1_hit;
  assign rd_addr_o    = s1_addr;
  assign mask_valid_o = s3_valid;
  assign mask_o       = s3_mask;
  assign zero_mode_o  = s3_zero;
endmodule

// File: rtl/pred_redirect.sv
module pred_redirect
  import pred_redir_pkg::*;
#(
  parameter int unsigned XLEN        = 64,
  parameter int unsigned NUM_ENTRIES = 16,
  localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [IDX_W-1:0]     cfg_idx_i,
  input  logic                 cfg_valid_i,
  input  logic                 cfg_is_fp_i,
  input  logic [REG_IDX_W-1:0] cfg_key_i,
  input  logic [REG_IDX_W-1:0] cfg_pred_idx_i,
  input  logic                 cfg_invert_i,
  input  logic                 cfg_zero_i,
  input  logic                 req_valid_i,
  input  logic                 req_is_fp_i,
  input  logic [REG_IDX_W-1:0] req_reg_i,
  output logic                 rf_rd_en_o,
  output logic [REG_IDX_W-1:0] rf_rd_addr_o,
  input  logic [XLEN-1:0]      rf_rd_data_i,
  output logic                 mask_valid_o,
  output logic [XLEN-1:0]      mask_o,
  output logic                 zero_mode_o
);
  pred_entry_t wdata;
  pred_entry_t entries [NUM_ENTRIES];
  pred_entry_t sel;
  logic        hit;

  assign wdata = '{valid: cfg_valid_i, is_fp: cfg_is_fp_i, key: cfg_key_i,
                   pred_idx: cfg_pred_idx_i, invert: cfg_invert_i,
                   zeroing: cfg_zero_i};

  pred_table #(.NUM_ENTRIES(NUM_ENTRIES)) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .idx_i     (cfg_idx_i),
    .wdata_i   (wdata),
    .entries_o (entries)
  );

  pred_match #(.NUM_ENTRIES(NUM_ENTRIES)) u_match (
    .entries_i (entries),
    .is_fp_i   (req_is_fp_i),
    .reg_i     (req_reg_i),
    .hit_o     (hit),
    .sel_o     (sel)
  );

  pred_mask_stage #(.XLEN(XLEN)) u_stage (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .hit_i        (hit),
    .sel_i        (sel),
    .rd_en_o      (rf_rd_en_o),
    .rd_addr_o    (rf_rd_addr_o),
    .rd_data_i    (rf_rd_data_i),
    .mask_valid_o (mask_valid_o),
    .mask_o       (mask_o),
    .zero_mode_o  (zero_mode_o)
  );
endmodule

// File: rtl/pred_redirect_chk.sv
module pred_redirect_chk #(
  parameter int unsigned XLEN = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            rf_rd_en_o,
  input logic            mask_valid_o,
  input logic [XLEN-1:0] mask_o,
  input logic            zero_mode_o
);
  logic [1:0] age;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      a_r1_quiet_in_reset: assert (!mask_valid_o && !rf_rd_en_o);
    end
  end

  a_r4_read_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age != 2'd0) && rf_rd_en_o |-> $past(req_valid_i));

  a_r5_fixed_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age == 2'd3) |-> (mask_valid_o == $past(req_valid_i, 3)));

  a_r8_miss_all_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age == 2'd3) && mask_valid_o && !$past(rf_rd_en_o, 2) |->
    ((&mask_o) && !zero_mode_o));
endmodule

bind pred_redirect pred_redirect_chk #(.XLEN(XLEN)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .rf_rd_en_o   (rf_rd_en_o),
  .mask_valid_o (mask_valid_o),
  .mask_o       (mask_o),
  .zero_mode_o  (zero_mode_o)
);

// File: tb/pred_redirect_tb.sv
module pred_redirect_tb_top;
  localparam int unsigned XLEN = 64;
  localparam int unsigned NE   = 16;
  localparam int unsigned IW   = $clog2(NE);
  // vector: [13] is_fp, [12:8] reg, [7] hit, [6:2] addr, [1] invert, [0] zeroing
  localparam int NV = 6;
  localparam logic [13:0] VECS [NV] = '{
    {1'b0, 5'd3,  1'b1, 5'd10, 1'b0, 1'b0},
    {1'b1, 5'd3,  1'b1, 5'd11, 1'b1, 1'b1},
    {1'b0, 5'd7,  1'b1, 5'd13, 1'b1, 1'b0},
    {1'b1, 5'd7,  1'b0, 5'd0,  1'b0, 1'b0},
    {1'b0, 5'd4,  1'b0, 5'd0,  1'b0, 1'b0},
    {1'b1, 5'd31, 1'b1, 5'd0,  1'b1, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_valid = 0, cfg_is_fp = 0, cfg_inv = 0, cfg_zero = 0;
  logic [IW-1:0] cfg_idx = '0;
  logic [4:0] cfg_key = '0, cfg_pidx = '0;
  logic req_valid = 0, req_is_fp = 0;
  logic [4:0] req_reg = '0;
  logic rd_en, mask_valid, zero_mode;
  logic [4:0] rd_addr;
  logic [XLEN-1:0] rd_data = '0, mask;
  logic [XLEN-1:0] rf_mem [32];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pred_redirect #(.XLEN(XLEN), .NUM_ENTRIES(NE)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_valid_i(cfg_valid),
    .cfg_is_fp_i(cfg_is_fp), .cfg_key_i(cfg_key), .cfg_pred_idx_i(cfg_pidx),
    .cfg_invert_i(cfg_inv), .cfg_zero_i(cfg_zero),
    .req_valid_i(req_valid), .req_is_fp_i(req_is_fp), .req_reg_i(req_reg),
    .rf_rd_en_o(rd_en), .rf_rd_addr_o(rd_addr), .rf_rd_data_i(rd_data),
    .mask_valid_o(mask_valid), .mask_o(mask), .zero_mode_o(zero_mode)
  );

  always @(posedge clk) if (rd_en) rd_data <= rf_mem[rd_addr];

  task automatic chk(input bit ok, input string req, input logic [XLEN-1:0] act,
                     input logic [XLEN-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input bit v, input bit fp, input int key,
                    input int pidx, input bit inv, input bit z);
    cfg_we = 1; cfg_idx = IW'(idx); cfg_valid = v; cfg_is_fp = fp;
    cfg_key = 5'(key); cfg_pidx = 5'(pidx); cfg_inv = inv; cfg_zero = z;
    @(negedge clk);
    cfg_we = 0;
  endtask

  function automatic logic [XLEN-1:0] exp_mask(input bit hit, input int addr,
                                               input bit inv);
    if (!hit) return '1;
    return inv ? ~rf_mem[addr] : rf_mem[addr];
  endfunction

  task automatic lookup(input bit fp, input int r, input bit hit, input int addr,
                        input bit inv, input bit z, input string req);
    req_valid = 1; req_is_fp = fp; req_reg = 5'(r);
    @(negedge clk);
    req_valid = 0;
    chk(rd_en == hit, {req, " rd_en (R4/R8)"}, XLEN'(rd_en), XLEN'(hit));
    if (hit) chk(rd_addr == 5'(addr), {req, " rd_addr R4"}, XLEN'(rd_addr), XLEN'(addr));
    @(negedge clk);
    chk(!mask_valid, {req, " early valid R5"}, XLEN'(mask_valid), '0);
    @(negedge clk);
    chk(mask_valid, {req, " mask_valid R5"}, XLEN'(mask_valid), 1);
    chk(mask == exp_mask(hit, addr, inv), {req, " mask"}, mask, exp_mask(hit, addr, inv));
    chk(zero_mode == (hit & z), {req, " zero_mode R9"}, XLEN'(zero_mode), XLEN'(hit & z));
  endtask

  initial begin
    for (int i = 0; i < 32; i++)
      rf_mem[i] = (i == 0) ? '0 : ({8{8'(i)}} ^ 64'h5A3C_0F96_C3A5_1E78);
    repeat (3) @(negedge clk);
    chk(!mask_valid && !rd_en, "R1 reset outputs", XLEN'({mask_valid, rd_en}), '0);
    rst_n = 1;
    @(negedge clk);
    // R1: reset left no valid entry, so a lookup misses
    lookup(0, 3, 0, 0, 0, 0, "R1 empty table");

    wr(0,  1, 0, 3,  10, 0, 0);
    wr(1,  1, 1, 3,  11, 1, 1);
    wr(2,  1, 0, 7,  12, 0, 1);
    wr(5,  1, 0, 7,  13, 1, 0);
    wr(15, 1, 1, 31, 0,  1, 0);

    // table walk: R3 R6 R7 R8 R9 R10 R11
    for (int v = 0; v < NV; v++)
      lookup(VECS[v][13], int'(VECS[v][12:8]), VECS[v][7], int'(VECS[v][6:2]),
             VECS[v][1], VECS[v][0], $sformatf("R3/R6/R7/R8/R10/R11 vec%0d", v));

    // R13 and R2: clear slot 5, look up on the very next edge
    wr(5, 0, 0, 7, 13, 1, 0);
    lookup(0, 7, 1, 12, 0, 1, "R13 R2 slot removed");
    // R2: rewrite slot 0, immediate lookup sees the new data
    wr(0, 1, 0, 3, 20, 1, 1);
    lookup(0, 3, 1, 20, 1, 1, "R2 rewrite");

    // R12: back-to-back requests
    req_valid = 1; req_is_fp = 0; req_reg = 5'd3;
    @(negedge clk);
    chk(rd_en && rd_addr == 5'd20, "R12 first read", XLEN'(rd_addr), 20);
    req_is_fp = 1; req_reg = 5'd3;
    @(negedge clk);
    chk(rd_en && rd_addr == 5'd11, "R12 second read", XLEN'(rd_addr), 11);
    req_is_fp = 0; req_reg = 5'd9;
    @(negedge clk);
    req_valid = 0;
    chk(!rd_en, "R12 third miss no read", XLEN'(rd_en), 0);
    chk(mask_valid && mask == ~rf_mem[20] && zero_mode, "R12 first result",
        mask, ~rf_mem[20]);
    @(negedge clk);
    chk(mask_valid && mask == ~rf_mem[11] && zero_mode, "R12 second result",
        mask, ~rf_mem[11]);
    @(negedge clk);
    chk(mask_valid && mask == '1 && !zero_mode, "R12 third result R8", mask, '1);
    @(negedge clk);
    chk(!mask_valid, "R12 stream ends", XLEN'(mask_valid), 0);

    // R1: reset mid-use clears the table
    rst_n = 0;
    @(negedge clk);
    chk(!mask_valid && !rd_en, "R1 reset again", XLEN'({mask_valid, rd_en}), '0);
    rst_n = 1;
    @(negedge clk);
    lookup(1, 3, 0, 0, 0, 0, "R1 table cleared");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule